// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block collects interrupt requests for a small processor core and turns them into a single prioritised request with a vector index. Sixteen sources feed it: a software break, seven external pins whose active edge software selects, and eight internal peripheral event pulses. Every source latches into a request bit. A maskable source reaches the core only when its enable bit is set and the global disable flag is clear. The software break bypasses both gates.

The core sees `irq_o` together with the index of the winning source. It takes the request by pulsing `cpu_ack_i`. In that same clock the controller sets the global disable flag and clears the request bit of the source it presented. Software reaches the request, enable, polarity and flag registers through a simple word-wide register port. It can clear request bits but can never set them.

External pins are asynchronous. Each one passes through a two-flop synchronizer and is then compared with its registered previous value. Because the comparison is made after the polarity inversion, rewriting a polarity bit while a pin is idle can itself raise a request. Software has to allow for this when it reconfigures an edge.

Top module: `irqc_top`

## Requirements
- R1: After reset all request, enable and polarity bits read 0, the global disable flag reads 1, and `irq_o` is 0.
- R2: A maskable source k (indices 1 to 15) is presented only while its request bit and enable bit are both 1 and the global disable flag is 0.
- R3: A write to register 0 clears request bit k (k from 1 to 15) where the write data bit k is 0, and leaves it unchanged where that bit is 1. Bit 0, the break request, is never changed by a write. No write ever sets a request bit.
- R4: A pulse on `brk_req_i` latches request bit 0. That bit is presented whatever the enable bits and the global disable flag hold.
- R5: When several sources are presentable, the lowest index wins, with the break at index 0 above all others. `irq_vec_o` carries the winning index.
- R6: A clock with `cpu_ack_i` and `irq_o` both high sets the global disable flag and clears only the presented request bit, at that clock edge. `cpu_ack_i` while `irq_o` is low changes nothing.
- R7: External pin j drives source j+1, and polarity bit j+1 of register 2 selects its edge: 0 for rising, 1 for falling. The request bit is set at the third rising clock edge after the pin changes to its active level.
- R8: Writing a polarity bit so that the selected level of a steady pin turns from inactive to active sets that source's request bit at the clock edge after the write.
- R9: A one-cycle pulse on `int_pulse_i[j]` sets request bit 8+j at the next clock edge.
- R10: A hardware event that sets a request bit wins over a software clear or an accept clear of the same bit in the same clock.
- R11: The register map is: address 0 requests, address 1 enables (bits 15:1; bit 0 reads 0), address 2 polarities (bits 7:1), address 3 global disable flag (bit 0). Read data follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin_i | input | 7 | Asynchronous external request pins |
| int_pulse_i | input | 8 | One-cycle internal peripheral event pulses |
| brk_req_i | input | 1 | Software break request pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| irq_o | output | 1 | Interrupt presented to the core |
| irq_vec_o | output | 4 | Index of the presented source |
| cpu_ack_i | input | 1 | Core accepts the presented interrupt |

## Verification
The bench targets collisions: a hardware event landing in the same clock as a software clear or an accept. A design that let the clear win would silently lose an interrupt. It also checks that writing ones to the request register sets nothing, and that the break stays presented with every enable off and the flag set. A design that gated the break would deadlock a trap handler. Edge timing is checked to the exact clock, including the request raised by a polarity rewrite on an idle pin and the absence of a request on the wrong edge. A stray acknowledge while nothing is presented must leave both the flag and the requests unchanged.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared register-select encoding for the interrupt request controller.
// Assumes a two-bit register address on the programming port.
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_REQ  = 2'd0,
        SEL_EN   = 2'd1,
        SEL_POL  = 2'd2,
        SEL_FLAG = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irqc_edge_det.sv
// Module irqc_edge_det
// Synchronises each asynchronous external pin through two flops, applies
// the per-pin polarity inversion and flags a one-cycle event when the
// inverted level rises against its registered previous value.
// Assumes pins idle low out of reset; a pin held high with polarity 0 at
// reset release produces one event.
module irqc_edge_det #(
    parameter int unsigned N_PIN = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_PIN-1:0] pin_i,
    input  logic [N_PIN-1:0] pol_i,
    output logic [N_PIN-1:0] edge_o
);

    for (genvar g = 0; g < N_PIN; g++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;
        logic lvl;

        // Polarity-adjusted level: 1 means the selected active level.
        assign lvl = sync_q ^ pol_i[g];

        // Two-flop synchroniser and previous-level register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_i[g];
                sync_q <= meta_q;
                prev_q <= lvl;
            end
        end

        // Event on the inactive-to-active transition.
        assign edge_o[g] = lvl & ~prev_q;
    end

endmodule

// File: rtl/irqc_req_bank.sv
// Module irqc_req_bank
// Holds one sticky request bit per source. Two clear vectors (software and
// accept) remove bits; the set vector adds bits and wins over both.
// Assumes the caller masks which bits software may clear.
module irqc_req_bank #(
    parameter int unsigned N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic [N_SRC-1:0] sw_clr_i,
    input  logic [N_SRC-1:0] acc_clr_i,
    output logic [N_SRC-1:0] req_o
);

    logic [N_SRC-1:0] req_q;

    // Request bits: clears first, then hardware sets override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= (req_q & ~(sw_clr_i | acc_clr_i)) | set_i;
        end
    end

    assign req_o = req_q;

endmodule

// File: rtl/irqc_prio.sv
// Module irqc_prio
// Fixed-priority selector: the lowest set index wins.
// Purely combinational; assumes IDX_W bits can hold N-1.
module irqc_prio #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [N-1:0]     pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top so the lowest pending index is written last.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

    assign any_o = |pend_i;

endmodule

// File: rtl/irqc_top.sv
// Module irqc_top
// Maskable interrupt request controller. Source 0 is the software break,
// sources 1..N_EXT are external pins, and the next N_INT are internal
// pulses. It holds the enable, polarity and global disable registers,
// gates requests, and presents the winner with an accept handshake.
// Assumes the internal pulses and the break are synchronous to clk.
module irqc_top #(
    parameter int unsigned N_EXT = 7,
    parameter int unsigned N_INT = 8,
    localparam int unsigned N_SRC = 1 + N_EXT + N_INT,
    localparam int unsigned VEC_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EXT-1:0] ext_pin_i,
    input  logic [N_INT-1:0] int_pulse_i,
    input  logic             brk_req_i,
    input  logic             reg_wr_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [N_SRC-1:0] reg_wdata_i,
    output logic [N_SRC-1:0] reg_rdata_o,
    output logic             irq_o,
    output logic [VEC_W-1:0] irq_vec_o,
    input  logic             cpu_ack_i
);

    import irqc_pkg::*;

    localparam logic [N_SRC-1:0] MASKABLE = {{(N_SRC-1){1'b1}}, 1'b0};
    localparam logic [N_SRC-1:0] POL_BITS = {{N_INT{1'b0}}, {N_EXT{1'b1}}, 1'b0};

    reg_sel_e         sel;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] pol_q;
    logic             flag_q;
    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] set_vec;
    logic [N_SRC-1:0] sw_clr;
    logic [N_SRC-1:0] acc_clr;
    logic [N_SRC-1:0] pend;
    logic [N_EXT-1:0] ext_edge;
    logic             accept;

    assign sel    = reg_sel_e'(reg_addr_i);
    assign accept = irq_o & cpu_ack_i;

    // Edge detection for the external pins.
    irqc_edge_det #(.N_PIN(N_EXT)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .pol_i  (pol_q[N_EXT:1]),
        .edge_o (ext_edge)
    );

    // Source ordering: break, external pins, internal pulses.
    assign set_vec = {int_pulse_i, ext_edge, brk_req_i};

    // Software clear: zero data bits of a request write, break excluded.
    assign sw_clr = (reg_wr_i && sel == SEL_REQ) ? (~reg_wdata_i & MASKABLE) : '0;

    // Accept clear: the presented source only.
    always_comb begin
        acc_clr = '0;
        if (accept) begin
            acc_clr[irq_vec_o] = 1'b1;
        end
    end

    irqc_req_bank #(.N_SRC(N_SRC)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (set_vec),
        .sw_clr_i  (sw_clr),
        .acc_clr_i (acc_clr),
        .req_o     (req_q)
    );

    // Enable and polarity registers, written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (reg_wr_i) begin
            if (sel == SEL_EN) begin
                en_q <= reg_wdata_i & MASKABLE;
            end
            if (sel == SEL_POL) begin
                pol_q <= reg_wdata_i & POL_BITS;
            end
        end
    end

    // Global disable flag: set by an accept, which wins over a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
        end else if (accept) begin
            flag_q <= 1'b1;
        end else if (reg_wr_i && sel == SEL_FLAG) begin
            flag_q <= reg_wdata_i[0];
        end
    end

    // Presentable sources: break ungated, the rest gated by enable and flag.
    assign pend = {req_q[N_SRC-1:1] & en_q[N_SRC-1:1] & {(N_SRC-1){~flag_q}}, req_q[0]};

    irqc_prio #(.N(N_SRC), .IDX_W(VEC_W)) u_prio (
        .pend_i (pend),
        .any_o  (irq_o),
        .idx_o  (irq_vec_o)
    );

    // Register read multiplexer.
    always_comb begin
        unique case (sel)
            SEL_REQ:  reg_rdata_o = req_q;
            SEL_EN:   reg_rdata_o = en_q;
            SEL_POL:  reg_rdata_o = pol_q;
            SEL_FLAG: reg_rdata_o = {{(N_SRC-1){1'b0}}, flag_q};
            default:  reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqc_checker.sv
// Module irqc_checker
// Temporal properties of the interrupt controller, bound to irqc_top.
// Assumes the request, enable, flag and set vectors are visible by name.
module irqc_checker #(
    parameter int unsigned N_SRC = 16,
    parameter int unsigned VEC_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic [VEC_W-1:0] irq_vec_o,
    input logic             cpu_ack_i,
    input logic [N_SRC-1:0] req_q,
    input logic [N_SRC-1:0] en_q,
    input logic             flag_q,
    input logic [N_SRC-1:0] set_vec
);

    logic [N_SRC-1:0] below;

    // Mask of indices with higher priority than the presented one.
    always_comb begin
        below = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (i < int'(irq_vec_o)) below[i] = 1'b1;
        end
    end

    assert_break_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_q[0] |-> (irq_o && irq_vec_o == '0));

    assert_gated_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && irq_vec_o != '0) |-> (req_q[irq_vec_o] && en_q[irq_vec_o] && !flag_q));

    assert_idle_without_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q == '0) |-> !irq_o);

    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((req_q & {en_q[N_SRC-1:1], 1'b1} & below) == '0));

    assert_accept_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && cpu_ack_i) |=> flag_q);

    assert_accept_clears_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && cpu_ack_i && !set_vec[irq_vec_o]) |=> !req_q[$past(irq_vec_o)]);

    assert_no_software_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & ~$past(req_q) & ~$past(set_vec)) == '0));

endmodule

bind irqc_top irqc_checker #(.N_SRC(N_SRC), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_o     (irq_o),
    .irq_vec_o (irq_vec_o),
    .cpu_ack_i (cpu_ack_i),
    .req_q     (req_q),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .set_vec   (set_vec)
);

// File: tb/tb_irqc_top.sv
`timescale 1ns/100ps
module tb_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ext_pin = '0;
    logic [7:0]  int_pulse = '0;
    logic        brk = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;
    logic [3:0]  irq_vec;
    logic        ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irqc_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_pin_i   (ext_pin),
        .int_pulse_i (int_pulse),
        .brk_req_i   (brk),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq),
        .irq_vec_o   (irq_vec),
        .cpu_ack_i   (ack)
    );

    // ---------------- behavioural reference model ----------------
    bit [15:0] m_req, m_en, m_pol;
    bit        m_flag;
    bit [6:0]  m_s1, m_s2, m_prev;

    function automatic int m_winner();
        for (int k = 0; k < 16; k++) begin
            if (k == 0 && m_req[0]) return 0;
            if (k > 0 && m_req[k] && m_en[k] && !m_flag) return k;
        end
        return -1;
    endfunction

    function automatic bit [15:0] m_read(input bit [1:0] a);
        case (a)
            2'd0: return m_req;
            2'd1: return m_en;
            2'd2: return m_pol;
            default: return {15'b0, m_flag};
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = '0; m_en = '0; m_pol = '0; m_flag = 1'b1;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            int w;
            bit [6:0] lvl;
            bit [15:0] nreq;
            bit nflag;
            w = m_winner();
            lvl = m_s2 ^ m_pol[7:1];
            nreq = m_req;
            nflag = m_flag;
            if (reg_wr && reg_addr == 2'd0)
                for (int k = 1; k < 16; k++) if (!reg_wdata[k]) nreq[k] = 1'b0;
            if (reg_wr && reg_addr == 2'd3) nflag = reg_wdata[0];
            if (w >= 0 && ack) begin
                nreq[w] = 1'b0;
                nflag = 1'b1;
            end
            nreq = nreq | {int_pulse, lvl & ~m_prev, brk};
            if (reg_wr && reg_addr == 2'd1) m_en = reg_wdata & 16'hFFFE;
            if (reg_wr && reg_addr == 2'd2) m_pol = reg_wdata & 16'h00FE;
            m_prev = lvl;
            m_s2 = m_s1;
            m_s1 = ext_pin;
            m_req = nreq;
            m_flag = nflag;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Compare the design with the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int w;
            w = m_winner();
            check(irq == (w >= 0), "R2 irq presence vs model", irq, w >= 0);
            if (w >= 0) check(irq_vec == w[3:0], "R5 vector vs model", irq_vec, w);
            check(reg_rdata == m_read(reg_addr), "R11 read data vs model", reg_rdata, m_read(reg_addr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input bit [1:0] a, input bit [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input bit [1:0] a, input bit [15:0] exp, input string tag);
        reg_addr = a;
        @(negedge clk);
        check(reg_rdata == exp, tag, reg_rdata, exp);
        #1;
    endtask

    task automatic expect_irq(input bit exp_irq, input int exp_vec, input string tag);
        @(negedge clk);
        check(irq == exp_irq, tag, irq, exp_irq);
        if (exp_irq) check(irq_vec == exp_vec[3:0], tag, irq_vec, exp_vec);
        #1;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        expect_reg(2'd0, 16'h0000, "R1 requests after reset");
        expect_reg(2'd1, 16'h0000, "R1 enables after reset");
        expect_reg(2'd2, 16'h0000, "R1 polarity after reset");
        expect_reg(2'd3, 16'h0001, "R1 flag after reset");
        expect_irq(1'b0, 0, "R1 no irq after reset");

        // R9 internal pulse, R2 gating by enable and flag
        int_pulse[2] = 1'b1; tick(); int_pulse = '0;
        expect_reg(2'd0, 16'h0400, "R9 internal pulse sets bit 10");
        expect_irq(1'b0, 0, "R2 disabled source not presented");
        wr(2'd1, 16'h0400);
        expect_irq(1'b0, 0, "R2 flag blocks enabled source");
        wr(2'd3, 16'h0000);
        expect_irq(1'b1, 10, "R2 presented once enabled and flag clear");

        // R3 software cannot set, can clear
        wr(2'd0, 16'hFFFF);
        expect_reg(2'd0, 16'h0400, "R3 writing ones sets nothing");
        wr(2'd0, 16'hFBFF);
        expect_reg(2'd0, 16'h0000, "R3 writing zero clears");
        expect_irq(1'b0, 0, "R3 cleared request withdrawn");

        // R11 enable bit 0 not writable
        wr(2'd1, 16'hFFFF);
        expect_reg(2'd1, 16'hFFFE, "R11 enable bit 0 reads 0");

        // R5 priority and R6 accept
        int_pulse = 8'h11; tick(); int_pulse = '0;
        expect_irq(1'b1, 8, "R5 lower index wins");
        do_ack();
        expect_reg(2'd3, 16'h0001, "R6 accept sets flag");
        expect_reg(2'd0, 16'h1000, "R6 accept clears only presented bit");
        expect_irq(1'b0, 0, "R6 flag masks after accept");
        wr(2'd3, 16'h0000);
        expect_irq(1'b1, 12, "R5 next source presented");
        wr(2'd3, 16'h0001);
        do_ack();
        expect_reg(2'd0, 16'h1000, "R6 ack while idle keeps requests");
        expect_reg(2'd3, 16'h0001, "R6 ack while idle keeps flag");
        wr(2'd0, 16'h0000);

        // R4 break ignores masks
        wr(2'd1, 16'h0000);
        brk = 1'b1; tick(); brk = 1'b0;
        expect_irq(1'b1, 0, "R4 break presented with all masks set");
        wr(2'd0, 16'h0000);
        expect_reg(2'd0, 16'h0001, "R3 write cannot clear break");
        do_ack();
        expect_reg(2'd0, 16'h0000, "R6 accept clears break");
        expect_irq(1'b0, 0, "R6 no irq after break accepted");

        // R7 rising edge timing on source 3
        ext_pin[2] = 1'b1;
        tick(); expect_reg(2'd0, 16'h0000, "R7 not set after 1st edge");
        tick(); expect_reg(2'd0, 16'h0000, "R7 not set after 2nd edge");
        tick(); expect_reg(2'd0, 16'h0008, "R7 set at 3rd edge");
        wr(2'd0, 16'h0000);

        // R8 polarity rewrite on an idle low pin (source 5)
        wr(2'd2, 16'h0020);
        expect_reg(2'd0, 16'h0000, "R8 not yet set at write edge");
        tick(); expect_reg(2'd0, 16'h0020, "R8 polarity change raises request");
        wr(2'd0, 16'h0000);
        ext_pin[4] = 1'b1;
        repeat (4) tick();
        expect_reg(2'd0, 16'h0000, "R7 rising ignored on falling polarity");
        ext_pin[4] = 1'b0;
        repeat (3) tick();
        expect_reg(2'd0, 16'h0020, "R7 falling edge sets source 5");
        wr(2'd0, 16'h0000);

        // R10 set beats simultaneous clears
        int_pulse[1] = 1'b1; reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000;
        tick(); int_pulse = '0; reg_wr = 1'b0;
        expect_reg(2'd0, 16'h0200, "R10 set wins over software clear");
        wr(2'd1, 16'h0200);
        wr(2'd3, 16'h0000);
        expect_irq(1'b1, 9, "R10 source 9 presented");
        int_pulse[1] = 1'b1; ack = 1'b1; tick(); int_pulse = '0; ack = 1'b0;
        expect_reg(2'd0, 16'h0200, "R10 set wins over accept clear");
        expect_reg(2'd3, 16'h0001, "R6 flag set by accept");
        wr(2'd0, 16'h0000);

        // Mixed traffic against the model
        for (int c = 0; c < 3000; c++) begin
            if ($urandom_range(0, 7) == 0) ext_pin = ext_pin ^ 7'($urandom_range(0, 127));
            int_pulse = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
            brk = ($urandom_range(0, 40) == 0);
            ack = ($urandom_range(0, 2) == 0);
            reg_wr = ($urandom_range(0, 3) == 0);
            reg_addr = 2'($urandom);
            reg_wdata = 16'($urandom);
            tick();
        end
        int_pulse = '0; brk = 1'b0; ack = 1'b0; reg_wr = 1'b0;
        tick();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule